// File: doc/BRIEF.md
# Numerically Controlled Oscillator Core

This block is the digital heart of a direct-synthesis signal source. A 32-bit phase register steps forward by a programmable frequency word on every clock. A phase offset is added to it, and the upper bits of the sum are turned into a 10-bit amplitude code for a downstream converter. The amplitude comes from a quarter-wave magnitude table that is computed at elaboration. Quadrant folding rebuilds the full period from that quarter, and the result is emitted as offset binary centred on 512.

The frequency word, the phase offset, the waveform select and the DC override are staged into an active set only when an update strobe is seen. The output therefore changes on a known cycle. The same strobe can zero the phase register for one cycle. A separate power-down input freezes the whole core at once: the phase register, the pipeline and the output all hold, and the valid flag drops. The output is pipelined with a fixed latency of two clocks, and a valid flag tracks that latency.

Top module: `nco_core`

## Requirements
- R1: While not powered down, the phase register adds the active frequency word on every clock edge and wraps modulo 2^32.
- R2: The frequency word, phase offset, waveform select and DC override inputs take effect only on an edge where the update strobe is 1. Changes without the strobe have no effect on the output.
- R3: The lookup phase is (phase register + active offset) mod 2^32, and only its top 12 bits k are used. The output code is 512 + round(511·sin(2π(k+0.5)/4096)) within ±1 code, so it is never 0.
- R4: Waveform select 1 gives the sine mapping. Waveform select 0 gives cosine, formed by adding a quarter turn (0x4000_0000) to the lookup phase.
- R5: With the DC override active, the output code is full scale (1023), while the phase register keeps advancing underneath.
- R6: An update strobe with the autoclear input at 1 loads zero into the phase register on that edge, and stepping resumes from zero on the next edge. Autoclear without the strobe does nothing.
- R7: While power-down is 1, the phase register and the output code hold and valid is 0. Update strobes still load the active set, but an autoclear is not applied.
- R8: The phase register value present in cycle n, with the active set of cycle n, determines the output in cycle n+2. Valid rises on the second edge after reset, and on the second edge after power-down ends.
- R9: Reset gives output code 512, valid 0, phase register 0, all active settings 0 (cosine, no DC override).
- R10: Phases k and k+2048 (top 12 bits) give codes that sum to exactly 1024. Phases k and 2047−k give identical codes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tuning_i | input | 32 | Frequency word, staged on update |
| offset_i | input | 32 | Phase offset, staged on update |
| sine_sel_i | input | 1 | 1 = sine, 0 = cosine, staged on update |
| dc_force_i | input | 1 | 1 = full-scale DC output, staged on update |
| acc_clr_en_i | input | 1 | Zero the phase register when sampled with update |
| update_i | input | 1 | Update strobe |
| core_off_i | input | 1 | Power-down: freeze the core |
| dac_code_o | output | 10 | Offset-binary amplitude code |
| code_valid_o | output | 1 | Output code is fresh |

## Verification
A wrong phase register value does not stay hidden. It shows as a code off the expected sine point two clocks later, and because the per-cycle model keeps its own phase, every later sample stays wrong. A wrong quadrant fold or a wrong table entry shows only when the phase crosses that quadrant or index, so the bench sweeps many frequency words and offsets. It also checks the exact half-turn and mirror identities, which catch a one-code asymmetry that the ±1 tolerance would hide. Hold and valid faults from power-down show on the first frozen cycle.

// File: rtl/nco_pkg.sv
package nco_pkg;

   // Q30 Taylor coefficients of sin(pi/2 * x) up to x^7
   localparam longint C1 = 64'sd1686629713;
   localparam longint C3 = 64'sd693598669;
   localparam longint C5 = 64'sd85569306;
   localparam longint C7 = 64'sd5026997;

   // Magnitude of table entry idx of a 2^aw quarter wave, sampled at
   // the middle of each step, scaled to peak.
   function automatic int quarter_mag(input int idx, input int aw, input int peak);
      longint x;
      longint x2;
      longint p;
      x  = longint'(2 * idx + 1) <<< (29 - aw);
      x2 = (x * x) >>> 30;
      p  = C5 - ((x2 * C7) >>> 30);
      p  = C3 - ((x2 * p) >>> 30);
      p  = C1 - ((x2 * p) >>> 30);
      p  = (x * p) >>> 30;
      return int'((p * longint'(peak) + (longint'(1) <<< 29)) >>> 30);
   endfunction

   typedef struct packed {
      logic sine;
      logic dc;
   } wave_mode_t;

endpackage

// File: rtl/nco_phase_acc.sv
module nco_phase_acc #(
   parameter int PHASE_W = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               hold_i,
   input  logic               clr_i,
   input  logic [PHASE_W-1:0] step_i,
   output logic [PHASE_W-1:0] acc_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         acc_o <= '0;
      else if (!hold_i) begin
         if (clr_i)
            acc_o <= '0;
         else
            acc_o <= acc_o + step_i;
      end
   end

   // R7
   acc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_i |=> $stable(acc_o));

   // R6
   acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_i && !hold_i) |=> (acc_o == '0));

endmodule

// File: rtl/nco_phase_map.sv
module nco_phase_map #(
   parameter int PHASE_W = 32,
   parameter int LUT_AW  = 10
) (
   input  logic               sine_i,
   input  logic [PHASE_W-1:0] acc_i,
   input  logic [PHASE_W-1:0] ofs_i,
   output logic [LUT_AW-1:0]  addr_o,
   output logic               neg_o
);

   localparam int LOW_W = PHASE_W - LUT_AW - 2;
   localparam logic [PHASE_W-1:0] QUARTER = {2'b01, {(PHASE_W-2){1'b0}}};

   logic [PHASE_W-1:0] ph;
   logic [1:0]         quad;
   logic [LUT_AW-1:0]  idx;

   always_comb begin
      ph     = acc_i + ofs_i + (sine_i ? '0 : QUARTER);
      quad   = ph[PHASE_W-1 -: 2];
      idx    = ph[PHASE_W-3 -: LUT_AW];
      addr_o = quad[0] ? ~idx : idx;
      neg_o  = quad[1];
   end

   generate
      if (LOW_W > 0) begin : g_low
         logic unused_low;
         assign unused_low = ^ph[LOW_W-1:0];
      end
   endgenerate

endmodule

// File: rtl/nco_quarter_rom.sv
module nco_quarter_rom #(
   parameter int AW   = 10,
   parameter int DW   = 9,
   parameter int PEAK = 511
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en_i,
   input  logic [AW-1:0] addr_i,
   output logic [DW-1:0] mag_o
);

   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] tbl [DEPTH];

   generate
      for (genvar gi = 0; gi < DEPTH; gi++) begin : g_tbl
         localparam int MAG = nco_pkg::quarter_mag(gi, AW, PEAK);
         assign tbl[gi] = DW'(MAG);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         mag_o <= '0;
      else if (en_i)
         mag_o <= tbl[addr_i];
   end

endmodule

// File: rtl/nco_core.sv
module nco_core #(
   parameter int PHASE_W = 32,
   parameter int AMP_W   = 10,
   parameter int LUT_AW  = 10
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [PHASE_W-1:0] tuning_i,
   input  logic [PHASE_W-1:0] offset_i,
   input  logic               sine_sel_i,
   input  logic               dc_force_i,
   input  logic               acc_clr_en_i,
   input  logic               update_i,
   input  logic               core_off_i,
   output logic [AMP_W-1:0]   dac_code_o,
   output logic               code_valid_o
);

   import nco_pkg::*;

   localparam int MAG_W = AMP_W - 1;
   localparam int PEAK  = (1 << MAG_W) - 1;
   localparam logic [AMP_W-1:0] MID  = AMP_W'(1) << MAG_W;
   localparam logic [AMP_W-1:0] FULL = '1;

   generate
      if (AMP_W < 2 || AMP_W > 16) begin : g_bad_amp
         $error("nco_core: AMP_W must lie in 2..16");
      end
      if (LUT_AW < 2 || LUT_AW > 12) begin : g_bad_lut
         $error("nco_core: LUT_AW must lie in 2..12");
      end
      if (PHASE_W < LUT_AW + 3 || PHASE_W > 48) begin : g_bad_phase
         $error("nco_core: PHASE_W must exceed LUT_AW+2 and be at most 48");
      end
   endgenerate

   // active set, staged on update
   logic [PHASE_W-1:0] ftw_act;
   logic [PHASE_W-1:0] ofs_act;
   wave_mode_t         mode_act;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ftw_act  <= '0;
         ofs_act  <= '0;
         mode_act <= '0;
      end else if (update_i) begin
         ftw_act       <= tuning_i;
         ofs_act       <= offset_i;
         mode_act.sine <= sine_sel_i;
         mode_act.dc   <= dc_force_i;
      end
   end

   logic [PHASE_W-1:0] acc;
   logic [LUT_AW-1:0]  rom_addr;
   logic               neg_w;
   logic [MAG_W-1:0]   mag_q;
   logic               run;

   assign run = !core_off_i;

   nco_phase_acc #(.PHASE_W(PHASE_W)) u_acc (
      .clk    (clk),
      .rst_n  (rst_n),
      .hold_i (core_off_i),
      .clr_i  (update_i & acc_clr_en_i),
      .step_i (ftw_act),
      .acc_o  (acc)
   );

   nco_phase_map #(.PHASE_W(PHASE_W), .LUT_AW(LUT_AW)) u_map (
      .sine_i (mode_act.sine),
      .acc_i  (acc),
      .ofs_i  (ofs_act),
      .addr_o (rom_addr),
      .neg_o  (neg_w)
   );

   nco_quarter_rom #(.AW(LUT_AW), .DW(MAG_W), .PEAK(PEAK)) u_rom (
      .clk    (clk),
      .rst_n  (rst_n),
      .en_i   (run),
      .addr_i (rom_addr),
      .mag_o  (mag_q)
   );

   // stage 1: side information beside the table read
   logic neg_q;
   logic dc_q;
   logic v1_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         neg_q <= 1'b0;
         dc_q  <= 1'b0;
         v1_q  <= 1'b0;
      end else if (run) begin
         neg_q <= neg_w;
         dc_q  <= mode_act.dc;
         v1_q  <= 1'b1;
      end else begin
         v1_q  <= 1'b0;
      end
   end

   // stage 2: sign fold and DC override
   logic [AMP_W-1:0] mag_ext;
   logic [AMP_W-1:0] code_w;

   always_comb begin
      mag_ext = {1'b0, mag_q};
      if (dc_q)
         code_w = FULL;
      else if (neg_q)
         code_w = MID - mag_ext;
      else
         code_w = MID + mag_ext;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         dac_code_o   <= MID;
         code_valid_o <= 1'b0;
      end else if (run) begin
         dac_code_o   <= code_w;
         code_valid_o <= v1_q;
      end else begin
         code_valid_o <= 1'b0;
      end
   end

   // R3
   code_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |-> (dac_code_o != '0));

   // R5
   dc_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (code_valid_o && $past(mode_act.dc, 2)) |-> (dac_code_o == FULL));

   // R8
   valid_lat_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_valid_o |-> (($past(core_off_i) == 1'b0) && ($past(core_off_i, 2) == 1'b0)));

   // R7
   out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      core_off_i |=> ($stable(dac_code_o) && !code_valid_o));

endmodule

// File: tb/nco_core_test.sv
module nco_core_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] tuning_i = '0;
   logic [31:0] offset_i = '0;
   logic        sine_sel_i = 1'b0;
   logic        dc_force_i = 1'b0;
   logic        acc_clr_en_i = 1'b0;
   logic        update_i = 1'b0;
   logic        core_off_i = 1'b0;
   logic [9:0]  dac_code_o;
   logic        code_valid_o;

   always #4 clk = ~clk;

   nco_core uut (
      .clk          (clk),
      .rst_n        (rst_n),
      .tuning_i     (tuning_i),
      .offset_i     (offset_i),
      .sine_sel_i   (sine_sel_i),
      .dc_force_i   (dc_force_i),
      .acc_clr_en_i (acc_clr_en_i),
      .update_i     (update_i),
      .core_off_i   (core_off_i),
      .dac_code_o   (dac_code_o),
      .code_valid_o (code_valid_o)
   );

   int    checks = 0;
   int    errors = 0;
   bit    done = 1'b0;
   bit    cmp_on = 1'b0;
   string cur_req = "R9";

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
      end
   endtask

   function automatic int ref_code(input logic [31:0] acc, input logic [31:0] ofs, input bit sine);
      logic [31:0] ph;
      int  k;
      real r;
      int  m;
      ph = acc + ofs + (sine ? 32'h0 : 32'h4000_0000);
      k  = int'(ph[31:20]);
      r  = 511.0 * $sin(2.0 * 3.14159265358979 * (real'(k) + 0.5) / 4096.0);
      if (r >= 0.0) m = $rtoi(r + 0.5);
      else          m = -$rtoi(-r + 0.5);
      return 512 + m;
   endfunction

   // behavioural reference model
   logic [31:0] m_acc = '0, m_ftw = '0, m_ofs = '0;
   bit m_sine = 0, m_dc = 0;
   int s1_code = 512, s2_code = 512;
   bit s1_v = 0, s2_v = 0, s1_dc = 0, s2_dc = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_acc = '0; m_ftw = '0; m_ofs = '0; m_sine = 0; m_dc = 0;
         s1_code = 512; s2_code = 512; s1_v = 0; s2_v = 0; s1_dc = 0; s2_dc = 0;
      end else begin
         if (!core_off_i) begin
            s2_code = s1_code; s2_v = s1_v; s2_dc = s1_dc;
            s1_code = m_dc ? 1023 : ref_code(m_acc, m_ofs, m_sine);
            s1_dc   = m_dc;
            s1_v    = 1;
            if (update_i && acc_clr_en_i) m_acc = '0;
            else                          m_acc = m_acc + m_ftw;
         end else begin
            s1_v = 0; s2_v = 0;
         end
         if (update_i) begin
            m_ftw = tuning_i; m_ofs = offset_i; m_sine = sine_sel_i; m_dc = dc_force_i;
         end
      end
   end

   // per-cycle comparison away from the active edge
   always @(negedge clk) begin
      if (cmp_on && !done) begin
         int act;
         int d;
         act = int'(dac_code_o);
         d = act - s2_code;
         if (d < 0) d = -d;
         chk(code_valid_o == s2_v, {cur_req, " valid"}, int'(code_valid_o), int'(s2_v));
         if (s2_dc && s2_v)
            chk(act == 1023, {cur_req, " R5 dc code"}, act, 1023);
         else if (!rst_n)
            chk(act == 512, {cur_req, " R9 reset code"}, act, 512);
         else
            chk(d <= 1, {cur_req, " code"}, act, s2_code);
      end
   end

   task automatic load(input logic [31:0] f, input logic [31:0] o,
                       input bit s, input bit d, input bit c);
      @(negedge clk);
      tuning_i = f; offset_i = o; sine_sel_i = s; dc_force_i = d;
      acc_clr_en_i = c; update_i = 1'b1;
      @(negedge clk);
      update_i = 1'b0; acc_clr_en_i = 1'b0;
   endtask

   task automatic run(input int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++; errors++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      int a;
      int b;
      // R9: reset state
      @(posedge clk);
      cmp_on = 1'b1;
      run(3);
      chk(dac_code_o == 10'd512, "R9 reset code", int'(dac_code_o), 512);
      chk(code_valid_o == 1'b0, "R9 reset valid", int'(code_valid_o), 0);
      rst_n = 1'b1;
      // R8: valid on second edge; default cosine at phase 0 is near full scale
      cur_req = "R8";
      @(negedge clk);
      chk(code_valid_o == 1'b0, "R8 valid after one edge", int'(code_valid_o), 0);
      @(negedge clk);
      chk(code_valid_o == 1'b1, "R8 valid after two edges", int'(code_valid_o), 1);
      chk(dac_code_o == 10'd1023, "R4 cosine at zero phase", int'(dac_code_o), 1023);

      cur_req = "R1 R3 R4 sine";
      load(32'h0100_0000, 32'h0, 1, 0, 0);
      run(300);
      cur_req = "R1 R3 R4 cosine";
      load(32'h0123_4567, 32'h1234_5678, 0, 0, 0);
      run(300);
      cur_req = "R1 wrap";
      load(32'hFFF0_0001, 32'h0, 1, 0, 0);
      run(200);
      load(32'h7FFF_FFFF, 32'hC000_0000, 0, 0, 0);
      run(200);

      // R2: inputs without strobe are ignored
      cur_req = "R2";
      tuning_i = 32'h0400_0000; offset_i = 32'h8000_0000;
      sine_sel_i = 1'b1; dc_force_i = 1'b1;
      run(100);

      cur_req = "R5";
      load(32'h0033_3333, 32'h0, 1, 1, 0);
      run(60);
      load(32'h0033_3333, 32'h0, 1, 0, 0);
      run(60);

      cur_req = "R6";
      load(32'h0050_0000, 32'h0, 1, 0, 1);
      run(40);
      acc_clr_en_i = 1'b1;
      run(30);
      acc_clr_en_i = 1'b0;
      load(32'h0050_0000, 32'h0, 0, 0, 1);
      run(40);

      cur_req = "R7";
      @(negedge clk); core_off_i = 1'b1;
      run(15);
      load(32'h0200_0000, 32'h1000_0000, 1, 0, 1);
      run(10);
      @(negedge clk); core_off_i = 1'b0;
      run(100);

      // R10: exact half-turn and mirror identities
      cur_req = "R10";
      load(32'h0, 32'h0640_0000, 1, 0, 1);
      run(4);
      a = int'(dac_code_o);
      load(32'h0, 32'h8640_0000, 1, 0, 1);
      run(4);
      b = int'(dac_code_o);
      chk(a + b == 1024, "R10 half-turn sum", a + b, 1024);
      load(32'h0, {12'd2047 - 12'd100, 20'h0}, 1, 0, 1);
      run(4);
      b = int'(dac_code_o);
      chk(a == b, "R10 quadrant mirror", b, a);

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule